// File: doc/BRIEF.md
# Reader Power-Mode State Controller

This block decides which subsystems of a contactless reader front-end receive power. Two asynchronous enable pins (a primary enable and a secondary, edge-sensitive wake pin) are synchronized and combined into one of three power states: off, sleep, or active. In the active state, a host-written control byte gates the transmitter, the receiver and the output-power level, and it selects the supply voltage. Every enable output is registered.

A rising edge on the secondary pin while the primary enable is low latches the reader awake. The reader then behaves as though the primary enable were high. It stays latched until both pins are low together. A spacing monitor watches the two synchronized pins and raises a sticky flag when the pins change closer together than a programmable number of clock cycles. The default count equals 1 ms at 200 MHz.

Top module: `rdr_pwr_ctrl`

## Requirements
- R1: When both pins are low and no wake is latched, the transmitter, receiver, high-frequency oscillator, low-frequency clock and auxiliary rail enables are all 0.
- R2: With the primary pin low, the secondary pin high and no wake latched (sleep), only the auxiliary rail and the low-frequency clock enables are 1.
- R3: With the primary pin high, the auxiliary rail and high-frequency oscillator enables are 1 and the low-frequency clock enable is 0, whatever the secondary pin does.
- R4: Control bit 7 set forces standby: transmitter and receiver enables are 0 regardless of bits 5 and 1.
- R5: With bits 7, 5 and 1 clear, transmitter and receiver are off. With only bit 1 set among those three, the receiver is on and the transmitter off.
- R6: With bit 7 clear and bit 5 set, both transmitter and receiver are on. Bit 4 then makes the half-power output 1, otherwise full power (half-power 0). The half-power output is 0 whenever the transmitter is off.
- R7: The supply-select output equals control bit 0 (1 = 5 V, 0 = 3.3 V).
- R8: A rising edge on the secondary pin while the primary pin is low latches the active state. The reader stays active while the secondary pin stays high, even if the primary pin rises and falls again.
- R9: The latched wake state clears when both pins are low at the same time.
- R10: After reset, the control byte is 0x80, all enables are 0 and the spacing flag is 0.
- R11: The spacing flag sets when one pin changes fewer than GAP_CYCLES cycles after the other pin changed (a separation of exactly GAP_CYCLES does not set it). Repeated changes of the same pin never set it. Once set, it stays set until reset.
- R12: A write strobe loads the data byte into the control register. Data presented without the strobe leaves every output unchanged.
- R13: Pin changes reach the enable outputs within 6 clock cycles, and control writes within 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_main_i | input | 1 | Primary enable pin (asynchronous) |
| en_wake_i | input | 1 | Secondary enable / wake pin (asynchronous) |
| ctl_wr_i | input | 1 | Control-byte write strobe |
| ctl_data_i | input | 8 | Control-byte write data |
| tx_on_o | output | 1 | Transmitter enable |
| rx_on_o | output | 1 | Receiver enable |
| hf_osc_on_o | output | 1 | High-frequency oscillator enable |
| lf_clk_on_o | output | 1 | Low-frequency auxiliary clock enable |
| aux_rail_on_o | output | 1 | Auxiliary supply rail enable |
| half_pwr_o | output | 1 | Half output power indication |
| sel_5v_o | output | 1 | Supply select, 1 = 5 V |
| spacing_err_o | output | 1 | Sticky pin-spacing violation flag |

## Verification
The bench reaches sleep the only way it can be reached: by raising the secondary pin while the primary is high, then dropping the primary. A design that woke on the secondary level rather than its edge would show active there. The wake tests toggle the primary pin while the wake is latched, and a controller that cleared the latch on primary activity would drop back to sleep. The spacing checks land on separations of exactly GAP_CYCLES and GAP_CYCLES-1, and on a fast double toggle of one pin. An off-by-one counter, or one that ignored which pin moved, would misreport these cases. Byte 0x20 checks that the transmitter bit also powers the receiver, and 0xA2 checks that bit 7 overrides both.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  typedef enum logic [1:0] {
    PM_OFF    = 2'd0,
    PM_SLEEP  = 2'd1,
    PM_ACTIVE = 2'd2
  } pmode_e;

  localparam int          CTL_W    = 8;
  localparam int          B_STBY   = 7;
  localparam int          B_TX     = 5;
  localparam int          B_HALF   = 4;
  localparam int          B_RX     = 1;
  localparam int          B_5V     = 0;
  localparam logic [7:0]  CTL_RST  = 8'h80;
endpackage

// File: rtl/rpc_pin_sync.sv
module rpc_pin_sync #(
  parameter int PINS   = 2,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pin_i,
  output logic [PINS-1:0] lvl_o,
  output logic [PINS-1:0] rise_o,
  output logic [PINS-1:0] chg_o
);
  genvar g;
  generate
    for (g = 0; g < PINS; g++) begin : g_pin
      logic [STAGES-1:0] sr;
      logic              prev;
      always_ff @(posedge clk) begin
        if (rst) begin
          sr   <= '0;
          prev <= 1'b0;
        end else begin
          sr   <= {sr[STAGES-2:0], pin_i[g]};
          prev <= sr[STAGES-1];
        end
      end
      assign lvl_o[g]  = sr[STAGES-1];
      assign rise_o[g] = sr[STAGES-1] & ~prev;
      assign chg_o[g]  = sr[STAGES-1] ^ prev;
    end
  endgenerate
endmodule

// File: rtl/rpc_mode_fsm.sv
module rpc_mode_fsm
  import rpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   main_lvl,
  input  logic   wake_lvl,
  input  logic   wake_rise,
  output pmode_e mode_o
);
  logic wake_q;

  always_ff @(posedge clk) begin
    if (rst)                      wake_q <= 1'b0;
    else if (!main_lvl && !wake_lvl) wake_q <= 1'b0;
    else if (wake_rise && !main_lvl) wake_q <= 1'b1;
  end

  always_comb begin
    if (main_lvl || wake_q) mode_o = PM_ACTIVE;
    else if (wake_lvl)      mode_o = PM_SLEEP;
    else                    mode_o = PM_OFF;
  end

  // R9: both pins low drops the latched wake
  p_wake_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (!main_lvl && !wake_lvl) |=> !wake_q);
endmodule

// File: rtl/rpc_gap_mon.sv
module rpc_gap_mon #(
  parameter int GAP_CYCLES = 200000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] chg_i,
  output logic       err_o
);
  localparam int CW = $clog2(GAP_CYCLES + 1);
  localparam logic [CW-1:0] GAP = CW'(GAP_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          seen_q;
  logic          last_q;
  logic          any_chg;
  logic          too_close;

  assign any_chg   = |chg_i;
  assign too_close = (chg_i == 2'b11) ||
                     (any_chg && seen_q && (last_q != chg_i[1]) && (cnt_q < GAP));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      last_q <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      if (too_close) err_o <= 1'b1;
      if (any_chg) begin
        cnt_q  <= CW'(1);
        seen_q <= 1'b1;
        last_q <= chg_i[1];
      end else if (cnt_q < GAP) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R11: flag is sticky
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
endmodule

// File: rtl/rpc_out_dec.sv
module rpc_out_dec
  import rpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  pmode_e mode_i,
  input  logic   stby_i,
  input  logic   tx_en_i,
  input  logic   half_i,
  input  logic   rx_en_i,
  input  logic   v5_i,
  output logic   tx_on_o,
  output logic   rx_on_o,
  output logic   hf_on_o,
  output logic   lf_on_o,
  output logic   rail_on_o,
  output logic   half_o,
  output logic   v5_o
);
  logic act, tx_n;
  assign act  = (mode_i == PM_ACTIVE);
  assign tx_n = act && !stby_i && tx_en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_on_o   <= 1'b0;
      rx_on_o   <= 1'b0;
      hf_on_o   <= 1'b0;
      lf_on_o   <= 1'b0;
      rail_on_o <= 1'b0;
      half_o    <= 1'b0;
      v5_o      <= 1'b0;
    end else begin
      tx_on_o   <= tx_n;
      rx_on_o   <= act && !stby_i && (tx_en_i || rx_en_i);
      hf_on_o   <= act;
      lf_on_o   <= (mode_i == PM_SLEEP);
      rail_on_o <= (mode_i != PM_OFF);
      half_o    <= tx_n && half_i;
      v5_o      <= v5_i;
    end
  end

  p_off_all_r1: assert property (@(posedge clk) disable iff (rst)
    (mode_i == PM_OFF) |=> !(tx_on_o || rx_on_o || hf_on_o || lf_on_o || rail_on_o));
  p_sleep_set_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_i == PM_SLEEP) |=> (rail_on_o && lf_on_o && !hf_on_o && !tx_on_o && !rx_on_o));
  p_stby_r4: assert property (@(posedge clk) disable iff (rst)
    stby_i |=> (!tx_on_o && !rx_on_o));
  p_half_tx_r6: assert property (@(posedge clk) disable iff (rst)
    half_o |-> tx_on_o);
endmodule

// File: rtl/rdr_pwr_ctrl.sv
module rdr_pwr_ctrl
  import rpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GAP_CYCLES  = 200000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_main_i,
  input  logic       en_wake_i,
  input  logic       ctl_wr_i,
  input  logic [7:0] ctl_data_i,
  output logic       tx_on_o,
  output logic       rx_on_o,
  output logic       hf_osc_on_o,
  output logic       lf_clk_on_o,
  output logic       aux_rail_on_o,
  output logic       half_pwr_o,
  output logic       sel_5v_o,
  output logic       spacing_err_o
);
  logic [1:0]       lvl, rise, chg;
  logic [CTL_W-1:0] ctl_q;
  pmode_e           mode;
  logic             unused_ctl_bits;

  rpc_pin_sync #(.PINS(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i({en_wake_i, en_main_i}),
    .lvl_o(lvl), .rise_o(rise), .chg_o(chg)
  );

  assign unused_ctl_bits = ^{rise[0], ctl_q[6], ctl_q[3:2]};

  rpc_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .main_lvl(lvl[0]), .wake_lvl(lvl[1]),
    .wake_rise(rise[1]), .mode_o(mode)
  );

  rpc_gap_mon #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk(clk), .rst(rst), .chg_i(chg), .err_o(spacing_err_o)
  );

  always_ff @(posedge clk) begin
    if (rst)           ctl_q <= CTL_RST;
    else if (ctl_wr_i) ctl_q <= ctl_data_i;
  end

  rpc_out_dec u_dec (
    .clk(clk), .rst(rst), .mode_i(mode),
    .stby_i(ctl_q[B_STBY]), .tx_en_i(ctl_q[B_TX]), .half_i(ctl_q[B_HALF]),
    .rx_en_i(ctl_q[B_RX]), .v5_i(ctl_q[B_5V]),
    .tx_on_o(tx_on_o), .rx_on_o(rx_on_o), .hf_on_o(hf_osc_on_o),
    .lf_on_o(lf_clk_on_o), .rail_on_o(aux_rail_on_o),
    .half_o(half_pwr_o), .v5_o(sel_5v_o)
  );

  // R12: no strobe, no change of the control byte
  p_ctl_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr_i |=> $stable(ctl_q));
endmodule

// File: tb/rdr_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module rdr_pwr_ctrl_bench;
  localparam int GAP = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_main = 1'b0, en_wake = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic tx, rx, hf, lf, rail, half, v5, serr;
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  rdr_pwr_ctrl #(.SYNC_STAGES(2), .GAP_CYCLES(GAP)) u_rdr_pwr_ctrl (
    .clk(clk), .rst(rst), .en_main_i(en_main), .en_wake_i(en_wake),
    .ctl_wr_i(wr), .ctl_data_i(wdata),
    .tx_on_o(tx), .rx_on_o(rx), .hf_osc_on_o(hf), .lf_clk_on_o(lf),
    .aux_rail_on_o(rail), .half_pwr_o(half), .sel_5v_o(v5), .spacing_err_o(serr)
  );

  // output vector order: {tx, rx, hf, lf, rail, half, v5}
  function automatic logic [6:0] outs();
    return {tx, rx, hf, lf, rail, half, v5};
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en_main = 1'b0; en_wake = 1'b0; wr = 1'b0;
    cyc(3);
    rst = 1'b0;
    cyc(2);
  endtask

  task automatic wr_ctl(input logic [7:0] b);
    @(negedge clk);
    wr = 1'b1; wdata = b;
    @(negedge clk);
    wr = 1'b0;
    cyc(3);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk({1'b0, outs()}, 8'b0000_0000, "R10 outputs after reset");
    chk({7'd0, serr}, 8'd0, "R10 flag after reset");
    chk({7'd0, v5}, 8'd0, "R10 ctl byte 0x80 bit0");
    chk({1'b0, outs()}, 8'b0000_0000, "R1 both pins low");
  endtask

  task automatic t_active_bytes();
    do_reset();
    en_main = 1'b1; cyc(8);
    chk({1'b0, outs()}, {1'b0, 7'b0010100}, "R3 main high, reset byte standby R4 R13");
    wr_ctl(8'h81); chk({1'b0, outs()}, {1'b0, 7'b0010101}, "R7 0x81 standby 5V");
    wr_ctl(8'h00); chk({1'b0, outs()}, {1'b0, 7'b0010100}, "R5 0x00");
    wr_ctl(8'h01); chk({1'b0, outs()}, {1'b0, 7'b0010101}, "R5 R7 0x01");
    wr_ctl(8'h02); chk({1'b0, outs()}, {1'b0, 7'b0110100}, "R5 0x02 rx only");
    wr_ctl(8'h03); chk({1'b0, outs()}, {1'b0, 7'b0110101}, "R5 0x03");
    wr_ctl(8'h30); chk({1'b0, outs()}, {1'b0, 7'b1110110}, "R6 0x30 half");
    wr_ctl(8'h31); chk({1'b0, outs()}, {1'b0, 7'b1110111}, "R6 0x31 half 5V");
    wr_ctl(8'h20); chk({1'b0, outs()}, {1'b0, 7'b1110100}, "R6 0x20 full");
    wr_ctl(8'h21); chk({1'b0, outs()}, {1'b0, 7'b1110101}, "R6 0x21 full 5V");
    wr_ctl(8'hA2); chk({1'b0, outs()}, {1'b0, 7'b0010100}, "R4 0xA2 override");
    wr_ctl(8'h10); chk({1'b0, outs()}, {1'b0, 7'b0010100}, "R6 half without tx");
    wr_ctl(8'h20);
    @(negedge clk); wdata = 8'h83; cyc(4);
    chk({1'b0, outs()}, {1'b0, 7'b1110100}, "R12 data without strobe ignored");
    chk({7'd0, serr}, 8'd0, "R11 no flag single pin");
  endtask

  task automatic t_sleep();
    do_reset();
    wr_ctl(8'h20);
    en_main = 1'b1; cyc(40);
    en_wake = 1'b1; cyc(8);
    chk({1'b0, outs()}, {1'b0, 7'b1110100}, "R3 wake pin ignored while main high");
    cyc(32);
    en_main = 1'b0; cyc(8);
    chk({1'b0, outs()}, {1'b0, 7'b0001100}, "R2 sleep, not woken by level");
    cyc(32);
    en_wake = 1'b0; cyc(8);
    chk({1'b0, outs()}, 8'b0000_0000, "R1 both low after sleep");
    chk({7'd0, serr}, 8'd0, "R11 spaced changes no flag");
  endtask

  task automatic t_wake();
    do_reset();
    wr_ctl(8'h02);
    en_wake = 1'b1; cyc(8);
    chk({1'b0, outs()}, {1'b0, 7'b0110100}, "R8 wake edge activates");
    cyc(32);
    en_main = 1'b1; cyc(40);
    en_main = 1'b0; cyc(8);
    chk({1'b0, outs()}, {1'b0, 7'b0110100}, "R8 latch survives main toggle");
    cyc(32);
    en_wake = 1'b0; cyc(8);
    chk({1'b0, outs()}, 8'b0000_0000, "R9 both low clears wake");
    cyc(32);
    en_main = 1'b1; cyc(40);
    en_wake = 1'b1; cyc(32);
    en_main = 1'b0; cyc(8);
    chk({1'b0, outs()}, {1'b0, 7'b0001100}, "R9 latch cleared, now sleep");
  endtask

  task automatic t_gap();
    do_reset();
    en_main = 1'b1; cyc(5);
    en_wake = 1'b1; cyc(6);
    chk({7'd0, serr}, 8'd1, "R11 close change sets flag");
    cyc(60);
    chk({7'd0, serr}, 8'd1, "R11 flag sticky");
    do_reset();
    en_main = 1'b1; cyc(GAP);
    en_wake = 1'b1; cyc(6);
    chk({7'd0, serr}, 8'd0, "R11 exact GAP no flag");
    cyc(40);
    en_wake = 1'b0; cyc(2);
    en_wake = 1'b1; cyc(6);
    chk({7'd0, serr}, 8'd0, "R11 same pin fast toggle no flag");
    cyc(GAP - 1 - 6);
    en_main = 1'b0; cyc(6);
    chk({7'd0, serr}, 8'd1, "R11 GAP-1 separation flags");
  endtask

  initial begin
    t_reset_state();
    t_active_bytes();
    t_sleep();
    t_wake();
    t_gap();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule